// File: doc/BRIEF.md
# Online Lane Fault Locator

This controller finds broken lanes in a parity-protected group of vertical links while ordinary traffic keeps flowing. The group has M working lanes plus R spare lanes. The controller drives an isolation mask to the lane datapath, and the datapath steers data around every lane whose mask bit is set. Each mask stays in place for K accepted transfers. During that window the controller counts parity failures reported by the receiving decoder. A configuration is judged faulty once the count reaches a threshold T. A threshold of 2 keeps a single upset from being read as a defect.

The first configuration is always the empty mask, which serves as the baseline. After that, the controller tries every mask with exactly one set bit, then every mask with two set bits, and so on up to R set bits. Within each size, masks are tried in ascending numeric order. A baseline that fails followed by an isolation that passes locates the defect: that mask is reported and kept as the repair configuration. If the sweep ends while the baseline is still failing, more than R lanes are broken, and the controller raises an uncorrectable flag so that a full offline test can be scheduled. The number of transfers a sweep takes has a fixed upper bound, so a real-time system can plan around it.

Top module: `online_lane_locator`

## Requirements
- R1: One cycle after `start` is high, `iso_mask` is all zeros (baseline), `done` is low and `fault_idx` is all zeros, whatever state the controller was in.
- R2: Every configuration stays on `iso_mask` for at least K transfers. Only cycles with `xfer_valid` high count as transfers.
- R3: After the baseline, every mask shown has between 1 and R bits set. Masks appear in non-decreasing order of set-bit count, and in increasing numeric value within one count.
- R4: A configuration fails when `parity_err` is high on T or more of its K transfers. Fewer errors than that, such as one upset with T=2, leave it healthy.
- R5: If the baseline failed and an isolation mask is healthy, the search stops at that mask. `fault_idx` then equals the mask (bit i set means lane i is faulty), `iso_mask` keeps that mask, `done` is high and `uncorrectable` is low.
- R6: If every mask has been tried and the baseline failed, `done` and `uncorrectable` go high, and `fault_idx` and `iso_mask` return to zero.
- R7: If the baseline was healthy, the sweep still runs to the end. It then finishes with `done` high, `uncorrectable` low, and `fault_idx` and `iso_mask` zero.
- R8: A complete sweep shows exactly the sum over r = 0..R of C(M+R, r) distinct configurations, so it needs at most K times that many transfers.
- R9: After `done` rises, all outputs hold their values under any further traffic until `start` is raised again. Raising `start` during a search restarts the search.
- R10: During and right after reset, `iso_mask`, `fault_idx`, `done` and `uncorrectable` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or restart a localization sweep |
| xfer_valid | input | 1 | A transfer is happening on the lanes this cycle |
| parity_err | input | 1 | The decoder syndrome for this transfer shows a parity failure |
| iso_mask | output | M+R | Lanes to isolate; bit i refers to lane i |
| fault_idx | output | M+R | Lanes found faulty (bit i = lane i) |
| done | output | 1 | The sweep has finished |
| uncorrectable | output | 1 | More than R lanes are faulty |

## Verification
Fault sets of size zero, one, two and three are placed at fixed and at random lane positions. Each size exercises a different ending: a healthy baseline with a full sweep, a hit among the single-lane masks, a hit among the two-lane masks, and an exhausted sweep with the uncorrectable flag. Single and double parity upsets injected into the baseline window of a fault-free group test the threshold: one upset must be absorbed, and two must be attributed to the first lane. Transfer gaps are random throughout. The bench watches the mask sequence at the port to confirm the hold length, the ordering, and the number of configurations in a full sweep.

// File: rtl/lane_iso_pkg.sv
package lane_iso_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MEAS = 2'd1,
      ST_SEEK = 2'd2
   } loc_state_e;

   function automatic int unsigned ones(input logic [31:0] v);
      int unsigned n;
      n = 0;
      for (int i = 0; i < 32; i++) n += int'(v[i]);
      return n;
   endfunction

endpackage

// File: rtl/fail_tally.sv
module fail_tally #(
   parameter int K = 8,
   parameter int T = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   input  logic syn,
   output logic last,
   output logic verdict
);
   localparam int XW = (K > 1) ? $clog2(K) : 1;

   logic [XW-1:0] xfer;

   assign last = en && (xfer == XW'(K - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)          xfer <= '0;
      else if (clr || last) xfer <= '0;
      else if (en)          xfer <= xfer + 1'b1;
   end

   // R2: the transfer count moves only on an accepted transfer
   a_r2_count_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(xfer));

   generate
      if (T == 1) begin : g_flag
         logic seen;
         always_ff @(posedge clk) begin
            if (!rst_n)           seen <= 1'b0;
            else if (clr || last) seen <= 1'b0;
            else if (en && syn)   seen <= 1'b1;
         end
         assign verdict = seen | (en & syn);
      end else begin : g_cnt
         localparam int FW = $clog2(T + 1);
         logic [FW-1:0] fcnt;
         always_ff @(posedge clk) begin
            if (!rst_n)                                fcnt <= '0;
            else if (clr || last)                      fcnt <= '0;
            else if (en && syn && (fcnt < FW'(T)))     fcnt <= fcnt + 1'b1;
         end
         assign verdict = ({1'b0, fcnt} + (FW + 1)'(en & syn)) >= (FW + 1)'(T);

         // R4: the failure count saturates at the threshold
         a_r4_fail_saturates: assert property (@(posedge clk) disable iff (!rst_n)
            fcnt <= FW'(T));
      end
   endgenerate

endmodule

// File: rtl/iso_walker.sv
module iso_walker #(
   parameter int N = 6,
   parameter int R = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         advance,
   output logic [N-1:0] cand,
   output logic         ready,
   output logic         exhausted
);
   localparam int RW = $clog2(R + 1) + 1;

   logic [N:0]    scan;
   logic [RW-1:0] pass;
   logic          seeking;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cand      <= '0;
         ready     <= 1'b0;
         exhausted <= 1'b0;
         seeking   <= 1'b0;
         scan      <= '0;
         pass      <= '0;
      end else if (restart) begin
         cand      <= '0;
         ready     <= 1'b1;
         exhausted <= 1'b0;
         seeking   <= 1'b0;
         scan      <= '0;
         pass      <= '0;
      end else if (advance) begin
         ready   <= 1'b0;
         seeking <= 1'b1;
         if (pass == '0) begin
            pass <= RW'(1);
            scan <= (N + 1)'(1);
         end else begin
            scan <= {1'b0, cand} + 1'b1;
         end
      end else if (seeking) begin
         if (scan[N]) begin
            if (int'(pass) == R) begin
               exhausted <= 1'b1;
               seeking   <= 1'b0;
            end else begin
               pass <= pass + 1'b1;
               scan <= (N + 1)'(1);
            end
         end else if (lane_iso_pkg::ones(32'(scan)) == 32'(pass)) begin
            cand    <= scan[N-1:0];
            ready   <= 1'b1;
            seeking <= 1'b0;
         end else begin
            scan <= scan + 1'b1;
         end
      end
   end

   // R3: a presented candidate never isolates more than R lanes
   a_r3_popcount_limit: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> ($countones(cand) <= R));

   // R3: a new candidate is larger in set-bit count, or numerically within one count
   a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !$past(ready) && !$past(restart) && $past(rst_n)) |->
         (($countones(cand) > $countones($past(cand))) ||
          (($countones(cand) == $countones($past(cand))) && (cand > $past(cand)))));

endmodule

// File: rtl/online_lane_locator.sv
module online_lane_locator #(
   parameter int M = 4,
   parameter int R = 2,
   parameter int K = 8,
   parameter int T = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           xfer_valid,
   input  logic           parity_err,
   output logic [M+R-1:0] iso_mask,
   output logic [M+R-1:0] fault_idx,
   output logic           done,
   output logic           uncorrectable
);
   import lane_iso_pkg::*;

   localparam int N = M + R;

   generate
      if (K < 3) begin : g_bad_k
         $error("online_lane_locator: K must exceed 2");
      end
      if (T < 1 || T > K) begin : g_bad_t
         $error("online_lane_locator: T must lie in 1..K");
      end
      if (M < 1 || R < 1 || N > 16) begin : g_bad_lanes
         $error("online_lane_locator: need M>=1, R>=1, M+R<=16");
      end
   endgenerate

   loc_state_e   state;
   logic         base_fail;
   logic [N-1:0] hold_mask;

   logic [N-1:0] w_cand;
   logic         w_ready, w_exhausted, w_advance;
   logic         t_en, t_last, t_verdict, found;

   assign t_en      = (state == ST_MEAS) && xfer_valid && !start;
   assign found     = (w_cand != '0) && base_fail && !t_verdict;
   assign w_advance = (state == ST_MEAS) && t_last && !found && !start;

   iso_walker #(.N(N), .R(R)) u_walker (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (start),
      .advance   (w_advance),
      .cand      (w_cand),
      .ready     (w_ready),
      .exhausted (w_exhausted)
   );

   fail_tally #(.K(K), .T(T)) u_tally (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start),
      .en      (t_en),
      .syn     (parity_err),
      .last    (t_last),
      .verdict (t_verdict)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state         <= ST_IDLE;
         base_fail     <= 1'b0;
         hold_mask     <= '0;
         fault_idx     <= '0;
         done          <= 1'b0;
         uncorrectable <= 1'b0;
      end else if (start) begin
         state         <= ST_MEAS;
         base_fail     <= 1'b0;
         hold_mask     <= '0;
         fault_idx     <= '0;
         done          <= 1'b0;
         uncorrectable <= 1'b0;
      end else begin
         unique case (state)
            ST_MEAS: begin
               if (t_last) begin
                  if (w_cand == '0) begin
                     base_fail <= t_verdict;
                     state     <= ST_SEEK;
                  end else if (found) begin
                     fault_idx <= w_cand;
                     hold_mask <= w_cand;
                     done      <= 1'b1;
                     state     <= ST_IDLE;
                  end else begin
                     state <= ST_SEEK;
                  end
               end
            end
            ST_SEEK: begin
               if (w_exhausted) begin
                  done          <= 1'b1;
                  uncorrectable <= base_fail;
                  hold_mask     <= '0;
                  state         <= ST_IDLE;
               end else if (w_ready) begin
                  state <= ST_MEAS;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign iso_mask = (state == ST_IDLE) ? hold_mask : w_cand;

   // R1: a start always returns to the baseline with cleared results
   a_r1_start_baseline: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (iso_mask == '0) && !done && (fault_idx == '0));

   // R5: a located fault stays applied as the repair mask
   a_r5_repair_held: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (fault_idx != '0)) |-> ((iso_mask == fault_idx) && !uncorrectable));

   // R6: an uncorrectable outcome carries no fault index and no isolation
   a_r6_uncorr_clean: assert property (@(posedge clk) disable iff (!rst_n)
      uncorrectable |-> (done && (fault_idx == '0) && (iso_mask == '0)));

   // R9: results hold until the next start
   a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(fault_idx) && $stable(uncorrectable)));

endmodule

// File: tb/online_lane_locator_tb.sv
module online_lane_locator_tb;
   localparam int M = 4;
   localparam int R = 2;
   localparam int K = 8;
   localparam int T = 2;
   localparam int N = M + R;
   localparam int CLK_PERIOD = 10;
   localparam int FULL_SWEEP = 1 + 6 + 15;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         xfer_valid = 1'b0;
   logic         parity_err = 1'b0;
   logic [N-1:0] iso_mask, fault_idx;
   logic         done, uncorrectable;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   online_lane_locator #(.M(M), .R(R), .K(K), .T(T)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .xfer_valid(xfer_valid),
      .parity_err(parity_err), .iso_mask(iso_mask), .fault_idx(fault_idx),
      .done(done), .uncorrectable(uncorrectable)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         tests++;
         fails++;
         $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit order_legal(input logic [N-1:0] prev, input logic [N-1:0] nxt);
      int p, q;
      p = $countones(prev);
      q = $countones(nxt);
      if (q < 1 || q > R) return 1'b0;
      return (q > p) || ((q == p) && (nxt > prev));
   endfunction

   // Expected outcome from the requirements: faults up to R are located
   // exactly; none means a clean sweep; more means uncorrectable.
   task automatic expect_for(input logic [N-1:0] faulty, input int ups,
                             output logic [N-1:0] eidx, output logic eunc,
                             output bit efull);
      int c;
      c = $countones(faulty);
      if (c == 0 && ups >= T) begin
         eidx = N'(1); eunc = 1'b0; efull = 1'b0;
      end else if (c == 0) begin
         eidx = '0; eunc = 1'b0; efull = 1'b1;
      end else if (c <= R) begin
         eidx = faulty; eunc = 1'b0; efull = 1'b0;
      end else begin
         eidx = '0; eunc = 1'b1; efull = 1'b1;
      end
   endtask

   task automatic run_search(input logic [N-1:0] faulty, input int ups, input string tag);
      logic [N-1:0] eidx, cur;
      logic eunc;
      bit   efull, hold_ok, order_ok;
      int   cnt, distinct, sent, cyc;
      expect_for(faulty, ups, eidx, eunc, efull);
      @(negedge clk);
      start = 1'b1; xfer_valid = 1'b0; parity_err = 1'b0;
      @(negedge clk);
      start = 1'b0;
      // R1
      check(iso_mask == '0 && !done && fault_idx == '0, "R1", {tag, " baseline after start"},
            int'(iso_mask), 0);
      cur = '0; cnt = 0; distinct = 1; hold_ok = 1; order_ok = 1; sent = 0; cyc = 0;
      while (!done && cyc < 20000) begin
         xfer_valid = (($urandom % 10) < 7);
         parity_err = xfer_valid && ((|(faulty & ~iso_mask)) || (sent < ups));
         if (xfer_valid) begin
            sent++;
            cnt++;
         end
         @(negedge clk);
         cyc++;
         if (!done && iso_mask != cur) begin
            if (cnt < K) hold_ok = 0;
            if (!order_legal(cur, iso_mask)) order_ok = 0;
            distinct++;
            cur = iso_mask;
            cnt = 0;
         end
      end
      xfer_valid = 1'b0; parity_err = 1'b0;
      check(done, "R8", {tag, " sweep finished"}, int'(done), 1);
      check(hold_ok, "R2", {tag, " K transfers per mask"}, int'(hold_ok), 1);
      check(order_ok, "R3", {tag, " candidate order"}, int'(order_ok), 1);
      if (eunc)
         check(uncorrectable == 1'b1 && fault_idx == '0, "R6", {tag, " uncorrectable"},
               int'(fault_idx), 0);
      else if (eidx == '0)
         check(uncorrectable == 1'b0 && fault_idx == '0, "R7", {tag, " healthy result"},
               int'(fault_idx), 0);
      else
         check(uncorrectable == 1'b0 && fault_idx == eidx, "R5", {tag, " fault index"},
               int'(fault_idx), int'(eidx));
      check(iso_mask == eidx, "R5", {tag, " repair mask"}, int'(iso_mask), int'(eidx));
      if (efull)
         check(distinct == FULL_SWEEP, "R8", {tag, " configurations swept"}, distinct, FULL_SWEEP);
   endtask

   initial begin
      logic [N-1:0] keep_idx, keep_mask, f;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R10
      check(iso_mask == '0 && fault_idx == '0 && !done && !uncorrectable, "R10",
            "outputs in reset", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(iso_mask == '0 && !done, "R10", "outputs after reset", int'(iso_mask), 0);

      run_search(6'b000000, 0, "no fault");
      run_search(6'b000001, 0, "lane 0");
      run_search(6'b100000, 0, "lane 5");
      run_search(6'b010010, 0, "pair 1,4");
      run_search(6'b100101, 0, "triple");
      // R4: one upset is filtered, two upsets fail the baseline
      run_search(6'b000000, 1, "R4 single upset");
      run_search(6'b000000, 2, "R4 double upset");

      // R9: results hold under further traffic with errors
      run_search(6'b001000, 0, "lane 3");
      keep_idx = fault_idx; keep_mask = iso_mask;
      repeat (60) begin
         xfer_valid = 1'b1; parity_err = ($urandom % 2) == 1;
         @(negedge clk);
      end
      xfer_valid = 1'b0; parity_err = 1'b0;
      check(done && fault_idx == keep_idx && iso_mask == keep_mask, "R9", "hold after done",
            int'(fault_idx), int'(keep_idx));

      // R9: restart in the middle of a search
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (40) begin
         xfer_valid = 1'b1; parity_err = 1'b1;
         @(negedge clk);
      end
      xfer_valid = 1'b0;
      check(!done, "R9", "mid search not done", int'(done), 0);
      run_search(6'b000100, 0, "R9 restart");

      for (int n = 0; n < 10; n++) begin
         f = '0;
         for (int b = 0; b < N; b++)
            if (($urandom % 100) < 20) f[b] = 1'b1;
         run_search(f, int'($urandom % 2), "random");
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule